// File: doc/BRIEF.md
# Polled and Interrupt-Driven Character Input Port

This block sits between a device that produces characters and a simple processor bus. Whenever the device pulses its strobe, the block captures the character that comes with it and raises a ready flag. Software can poll that flag in the status register. It can also set an enable bit in the control register, so that the ready flag raises an interrupt request instead.

Reading the status or data register counts as servicing the port and drops the ready flag. An acknowledge from the processor withdraws a pending request until the next character arrives. If a character arrives before the previous one has been taken, the new one replaces it and a sticky overrun flag records the loss.

Every register is one byte wide and sits at a fixed byte address. Read data is registered: it appears on the cycle after the read and holds until the next read.

Top module: `key_input_iface`

## Requirements
- R1: A synchronous active-high reset clears the held character, the ready, overrun and enable flags, the acknowledge memory, the read data and the interrupt request.
- R2: A cycle with devStrobe high stores devChar in the data register (address 0) and sets the ready flag, which is status bit 1, so status reads 0x02 when only the ready flag is set.
- R3: A read of the status register (address 4) returns the flags as they were before the read, then clears both the ready flag and the overrun flag.
- R4: A read of the data register returns the held character and clears the ready flag. When a strobe coincides with that read, the old character is returned and the flag stays set for the new one.
- R5: A strobe while the ready flag is set overwrites the held character and sets the overrun flag (status bit 0). The overrun flag survives data reads and is cleared only by a status read or by reset.
- R6: The control register (address 8) holds the interrupt enable in bit 1, and its other bits read as zero. Writes to the data and status addresses change nothing.
- R7: irqReq is high exactly when the ready flag is set, the enable bit is set and the current character has not been acknowledged.
- R8: An irqAck pulse drops irqReq on the next cycle. The request returns only when a new character is strobed in.
- R9: A read of any address other than 0, 4 or 8 returns zero. busRdata changes only on the clock edge that ends a read cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| devChar | input | CHAR_W | Character from the device |
| devStrobe | input | 1 | One-cycle pulse: devChar is valid |
| busAddr | input | ADDR_W | Byte address of the access |
| busRead | input | 1 | Read request this cycle |
| busWrite | input | 1 | Write request this cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| irqReq | output | 1 | Interrupt request |
| irqAck | input | 1 | Interrupt acknowledge from the processor |

## Verification
The bench builds the block with its default parameters: 8-bit characters and a 4-bit address. With those values all 256 character codes can be swept through the full strobe, status-read and data-read cycle, and all sixteen addresses can be probed for the zero readback of unmapped locations. The directed part of the bench targets the orderings where two sources collide in one cycle: a strobe during a data read, a strobe while a character is still pending, and an acknowledge against a fresh character.

// File: rtl/key_input_pkg.sv
package key_input_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } rdSel_t;

  typedef struct packed {
    logic   loadChar;
    logic   clrReady;
    logic   clrOvr;
    logic   wrCtrl;
    logic   ackIrq;
    logic   rdEn;
    rdSel_t rdSel;
  } kbdStrobe_t;

endpackage

// File: rtl/key_input_ctrl.sv
module key_input_ctrl
  import key_input_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int STAT_OFS = 4,
  parameter int CTRL_OFS = 8
) (
  input  logic              devStrobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic              irqAck,
  output kbdStrobe_t        st
);

  localparam logic [ADDR_W-1:0] DataAddr = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_OFS);

  logic hitData, hitStat, hitCtrl;

  always_comb begin
    hitData = (busAddr == DataAddr);
    hitStat = (busAddr == StatAddr);
    hitCtrl = (busAddr == CtrlAddr);
  end

  always_comb begin
    st          = '0;
    st.loadChar = devStrobe;
    st.ackIrq   = irqAck;
    st.rdEn     = busRead;
    st.wrCtrl   = busWrite && hitCtrl;
    st.clrReady = busRead && (hitData || hitStat);
    st.clrOvr   = busRead && hitStat;
    if (!busRead)     st.rdSel = SEL_NONE;
    else if (hitData) st.rdSel = SEL_DATA;
    else if (hitStat) st.rdSel = SEL_STAT;
    else if (hitCtrl) st.rdSel = SEL_CTRL;
    else              st.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/key_input_dpath.sv
module key_input_dpath
  import key_input_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int READY_BIT = 1,
  parameter int OVR_BIT   = 0,
  parameter int IEN_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  kbdStrobe_t        st,
  input  logic [CHAR_W-1:0] devChar,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq
);

  logic [CHAR_W-1:0] charQ;
  logic              readyQ, ovrQ, intEnQ, ackedQ;
  logic [DATA_W-1:0] rdataQ, rdMux, statByte, ctrlByte;

  always_comb begin
    statByte            = '0;
    statByte[READY_BIT] = readyQ;
    statByte[OVR_BIT]   = ovrQ;
    ctrlByte            = '0;
    ctrlByte[IEN_BIT]   = intEnQ;
    unique case (st.rdSel)
      SEL_DATA: rdMux = DATA_W'(charQ);
      SEL_STAT: rdMux = statByte;
      SEL_CTRL: rdMux = ctrlByte;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      charQ  <= '0;
      readyQ <= 1'b0;
      ovrQ   <= 1'b0;
      intEnQ <= 1'b0;
      ackedQ <= 1'b0;
      rdataQ <= '0;
    end else begin
      if (st.loadChar) charQ <= devChar;
      if (st.loadChar)      readyQ <= 1'b1;
      else if (st.clrReady) readyQ <= 1'b0;
      if (st.loadChar && readyQ) ovrQ <= 1'b1;
      else if (st.clrOvr)        ovrQ <= 1'b0;
      if (st.wrCtrl) intEnQ <= busWdata[IEN_BIT];
      if (st.loadChar)    ackedQ <= 1'b0;
      else if (st.ackIrq) ackedQ <= 1'b1;
      if (st.rdEn) rdataQ <= rdMux;
    end
  end

  assign busRdata = rdataQ;
  assign irqReq   = readyQ && intEnQ && !ackedQ;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    st.loadChar |=> (readyQ && charQ == $past(devChar)));

  assert_stat_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (st.clrOvr && !st.loadChar) |=> (!readyQ && !ovrQ));

  assert_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (st.loadChar && readyQ) |=> ovrQ);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> (readyQ && intEnQ));

  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (st.ackIrq && !st.loadChar) |=> !irqReq);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !st.rdEn |=> $stable(busRdata));

endmodule

// File: rtl/key_input_iface.sv
module key_input_iface
  import key_input_pkg::*;
#(
  parameter int CHAR_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int STAT_OFS = 4,
  parameter int CTRL_OFS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] devChar,
  input  logic              devStrobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              irqReq,
  input  logic              irqAck
);

  localparam int DataW = 8;

  kbdStrobe_t st;

  key_input_ctrl #(
    .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS)
  ) ctrl_i (
    .devStrobe(devStrobe), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .irqAck(irqAck), .st(st)
  );

  key_input_dpath #(
    .CHAR_W(CHAR_W), .DATA_W(DataW), .READY_BIT(1), .OVR_BIT(0), .IEN_BIT(1)
  ) dpath_i (
    .clk(clk), .rst(rst), .st(st), .devChar(devChar),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq)
  );

endmodule

// File: tb/key_input_iface_tb.sv
`timescale 1ns/1ps
module key_input_iface_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] devChar = '0;
  logic       devStrobe = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busRead = 1'b0;
  logic       busWrite = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqReq;
  logic       irqAck = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  key_input_iface dut_i (
    .clk(clk), .rst(rst), .devChar(devChar), .devStrobe(devStrobe),
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq), .irqAck(irqAck)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] c);
    devChar = c; devStrobe = 1'b1;
    cyc();
    devStrobe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    busAddr = a; busRead = 1'b1;
    cyc();
    busRead = 1'b0;
    v = busRdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    cyc();
    busWrite = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got 1 expected 0");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); cyc(); cyc();
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", busRdata, 8'h00);
    check("R1 irq", {7'd0, irqReq}, 8'h00);
    rd(4'd4, v); check("R1 status", v, 8'h00);
    rd(4'd0, v); check("R1 data", v, 8'h00);
    rd(4'd8, v); check("R1 ctrl", v, 8'h00);

    // R2/R3/R4 sweep of every character code
    for (int c = 0; c < 256; c++) begin
      strobe(8'(c));
      rd(4'd4, v); check("R3 status pre-read value (R2 ready)", v, 8'h02);
      rd(4'd4, v); check("R3 status cleared", v, 8'h00);
      strobe(8'(c));
      rd(4'd0, v); check("R2 data latched", v, 8'(c));
      rd(4'd4, v); check("R4 data read clears ready", v, 8'h00);
    end

    // R5 overrun
    strobe(8'h11); strobe(8'h22);
    rd(4'd0, v); check("R5 overwrite", v, 8'h22);
    rd(4'd4, v); check("R5 overrun sticky after data read", v, 8'h01);
    rd(4'd4, v); check("R5 overrun cleared by status read", v, 8'h00);

    // R4 read colliding with strobe
    strobe(8'h33);
    devChar = 8'h44; devStrobe = 1'b1; busAddr = 4'd0; busRead = 1'b1;
    cyc();
    devStrobe = 1'b0; busRead = 1'b0; v = busRdata;
    check("R4 collision returns old char", v, 8'h33);
    rd(4'd4, v); check("R4 collision keeps ready (R5 overrun)", v, 8'h03);
    rd(4'd0, v); check("R4 collision new char", v, 8'h44);

    // R6 control and ignored writes
    wr(4'd8, 8'hFF);
    rd(4'd8, v); check("R6 ctrl enable bit only", v, 8'h02);
    wr(4'd0, 8'h77); wr(4'd4, 8'h77);
    rd(4'd0, v); check("R6 data write ignored", v, 8'h44);
    rd(4'd4, v); check("R6 status write ignored", v, 8'h00);
    wr(4'd8, 8'hFD);
    rd(4'd8, v); check("R6 ctrl cleared", v, 8'h00);

    // R7 interrupt gating
    strobe(8'h55);
    check("R7 irq low when disabled", {7'd0, irqReq}, 8'h00);
    wr(4'd8, 8'h02);
    check("R7 irq high when enabled", {7'd0, irqReq}, 8'h01);
    rd(4'd4, v);
    check("R7 irq drops on status read", {7'd0, irqReq}, 8'h00);

    // R8 acknowledge
    strobe(8'h66);
    check("R8 irq raised", {7'd0, irqReq}, 8'h01);
    irqAck = 1'b1; cyc(); irqAck = 1'b0;
    check("R8 irq withdrawn on ack", {7'd0, irqReq}, 8'h00);
    rd(4'd4, v); check("R8 ready survives ack", v, 8'h02);
    strobe(8'h67);
    check("R8 irq back on new char", {7'd0, irqReq}, 8'h01);
    rd(4'd0, v); check("R8 data", v, 8'h67);

    // R9 unmapped addresses and hold
    strobe(8'h99);
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        rd(4'(a), v); check("R9 unmapped reads zero", v, 8'h00);
      end
    end
    rd(4'd8, v);
    cyc(); cyc();
    check("R9 rdata holds", busRdata, 8'h02);
    rd(4'd0, v); check("R9 data after probes", v, 8'h99);

    finishRun();
  end

endmodule